// File: doc/BRIEF.md
# Adaptive binary arithmetic decoder

This block turns a single fixed-point code value back into the short bit frame that an adaptive binary arithmetic encoder packed into it. It holds no side information about symbol statistics. It starts from equal zero and one counts and from the full coding interval. It then rebuilds the probability model one decoded bit at a time, applying the same adaptation and the same interval arithmetic as the encoder. Because both sides compute identical interval bounds, every code value inside the encoder's final interval gives back the original frame.

A start pulse loads the code value and the frame length. For each output position the block computes the split point of the current interval with a multicycle restoring divider. It decides whether the code value falls below or above that point and emits the bit with a one-cycle strobe. It then narrows the interval and bumps the count of the decoded symbol. A done level follows the last bit and stays up until the next frame is started. The divider's bits-per-cycle factor is a parameter, so each bit can take fewer cycles at the cost of a longer logic chain.

Top module: `adec_top`

## Requirements
- R1: After reset, bit_valid and done are both 0.
- R2: A start pulse is accepted only while no frame is being decoded. Acceptance loads tag_in and frame_len and clears done. A start pulse during decoding is ignored, and the frame in progress completes unchanged.
- R3: For each position, with c0 and c1 the current zero and one counts, the split point is floor(range*c0/(c0+c1)). The bit decodes as 0 when tag minus low is below the split point, and as 1 otherwise.
- R4: The interval starts at low = 0 and range = 2^WIDTH-1. After a 0, range becomes the split point. After a 1, low grows by the split point and range shrinks by it. The range never reaches zero.
- R5: Both counts start at 1 for each frame. After a bit is decoded, only the count of that bit's value grows by 1, so c0+c1 equals the number of decoded bits plus 2.
- R6: Any tag in [low, low+range) of the encoder's final interval reproduces the frame exactly, bit 0 first. This includes the lowest and highest values of that interval.
- R7: bit_valid is a one-cycle pulse. With CW = clog2(MAX_BITS+3), P = ceil((WIDTH+CW)/STEPS_PER_CYCLE)+2, and the start pulse sampled at clock edge S, bit i (counting from 0) is valid right after edge S+(i+1)*P. No other cycle has bit_valid high.
- R8: For a frame of L bits, done goes high right after edge S+L*P+1 and holds until the next accepted start. A length of 0 gives done after edge S+1 with no bits.
- R9: A frame_len above MAX_BITS is treated as MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding a frame (trigger from the encoder) |
| tag_in | input | WIDTH | Code value produced by the encoder |
| frame_len | input | clog2(MAX_BITS+1) | Number of bits to recover |
| bit_out | output | 1 | Recovered bit |
| bit_valid | output | 1 | One-cycle strobe qualifying bit_out |
| done | output | 1 | High after the last bit until the next start |

## Verification
The hardest case to reach is a code value sitting exactly on an edge of the encoder's final interval. There a rounding mismatch of one unit in any split point flips a late bit. The stimulus drives the lowest and the highest value of that interval, as well as interior values, over all-zero, all-one and random frames. A second start pulse with a different code value and length is injected in the middle of a frame. This shows the running decode does not react to it.

// File: rtl/adec_pkg.sv
package adec_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_WAIT  = 2'd2
   } adec_state_t;

   // number of divider iterations for a dividend of num_w bits
   function automatic int div_iterations(input int num_w, input int steps);
      return (num_w + steps - 1) / steps;
   endfunction

endpackage

// File: rtl/adec_model.sv
// Adaptive zero/one occurrence counts, rebuilt per frame.
module adec_model #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             upd,
   input  logic             sym,
   output logic [CNT_W-1:0] cnt0,
   output logic [CNT_W-1:0] cnt1,
   output logic [CNT_W-1:0] total
);

   logic [CNT_W-1:0] c0_q, c1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c0_q <= CNT_W'(1);
         c1_q <= CNT_W'(1);
      end else if (clear) begin
         c0_q <= CNT_W'(1);
         c1_q <= CNT_W'(1);
      end else if (upd) begin
         if (sym) c1_q <= c1_q + CNT_W'(1);
         else     c0_q <= c0_q + CNT_W'(1);
      end
   end

   assign cnt0  = c0_q;
   assign cnt1  = c1_q;
   assign total = c0_q + c1_q;

endmodule

// File: rtl/adec_divider.sv
// Multicycle restoring divider, STEPS quotient bits per clock.
module adec_divider #(
   parameter int NUM_W = 69,
   parameter int DEN_W = 5,
   parameter int STEPS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quo,
   output logic             vld
);
   import adec_pkg::*;

   localparam int ITER  = div_iterations(NUM_W, STEPS);
   localparam int PAD_W = ITER * STEPS;
   localparam int CNT_B = $clog2(ITER + 1);

   if (STEPS < 1) begin : g_bad_steps
      $error("adec_divider: STEPS must be at least 1");
   end
   if (DEN_W < 2) begin : g_bad_den
      $error("adec_divider: DEN_W must be at least 2");
   end

   logic [PAD_W-1:0] dq_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_B-1:0] cnt_q;
   logic             run_q;
   logic             vld_q;
   logic [PAD_W-1:0] load_val;

   // dividend alignment variant
   if (PAD_W > NUM_W) begin : g_pad
      assign load_val = {{(PAD_W-NUM_W){1'b0}}, num};
   end else begin : g_nopad
      assign load_val = num;
   end

   // unrolled chain of restoring steps
   logic [PAD_W-1:0] dq_s [0:STEPS];
   logic [DEN_W-1:0] rm_s [0:STEPS];

   assign dq_s[0] = dq_q;
   assign rm_s[0] = rem_q;

   for (genvar g = 0; g < STEPS; g++) begin : g_step
      logic [DEN_W:0] trial;
      logic           ge;
      assign trial       = {rm_s[g], dq_s[g][PAD_W-1]};
      assign ge          = (trial >= {1'b0, den_q});
      assign rm_s[g+1]   = ge ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
      assign dq_s[g+1]   = {dq_s[g][PAD_W-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_q  <= '0;
         rem_q <= '0;
         den_q <= DEN_W'(1);
         cnt_q <= '0;
         run_q <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (go) begin
            dq_q  <= load_val;
            rem_q <= '0;
            den_q <= den;
            cnt_q <= CNT_B'(ITER);
            run_q <= 1'b1;
         end else if (run_q) begin
            dq_q  <= dq_s[STEPS];
            rem_q <= rm_s[STEPS];
            cnt_q <= cnt_q - CNT_B'(1);
            if (cnt_q == CNT_B'(1)) begin
               run_q <= 1'b0;
               vld_q <= 1'b1;
            end
         end
      end
   end

   assign quo = dq_q[NUM_W-1:0];
   assign vld = vld_q;

endmodule

// File: rtl/adec_interval.sv
// Current coding interval [low, low+range).
module adec_interval #(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             upd,
   input  logic             sym,
   input  logic [WIDTH-1:0] split,
   output logic [WIDTH-1:0] low,
   output logic [WIDTH-1:0] rng
);

   logic [WIDTH-1:0] low_q, rng_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
         rng_q <= '1;
      end else if (clear) begin
         low_q <= '0;
         rng_q <= '1;
      end else if (upd) begin
         if (sym) begin
            low_q <= low_q + split;
            rng_q <= rng_q - split;
         end else begin
            rng_q <= split;
         end
      end
   end

   assign low = low_q;
   assign rng = rng_q;

endmodule

// File: rtl/adec_top.sv
// Adaptive binary arithmetic decoder, frame oriented.
module adec_top #(
   parameter int WIDTH           = 64,
   parameter int MAX_BITS        = 16,
   parameter int STEPS_PER_CYCLE = 1,
   localparam int LEN_W          = $clog2(MAX_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] tag_in,
   input  logic [LEN_W-1:0] frame_len,
   output logic             bit_out,
   output logic             bit_valid,
   output logic             done
);
   import adec_pkg::*;

   localparam int CNT_W = $clog2(MAX_BITS + 3);
   localparam int PW    = WIDTH + CNT_W;

   if (MAX_BITS < 1) begin : g_bad_len
      $error("adec_top: MAX_BITS must be at least 1");
   end
   if (WIDTH < 3 * MAX_BITS) begin : g_bad_width
      $error("adec_top: WIDTH too small to keep the range nonzero");
   end
   if (STEPS_PER_CYCLE < 1 || STEPS_PER_CYCLE > PW) begin : g_bad_steps
      $error("adec_top: STEPS_PER_CYCLE out of range");
   end

   adec_state_t      state_q;
   logic [WIDTH-1:0] tag_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] idx_q;
   logic             bit_q, valid_q, done_q;

   logic [CNT_W-1:0] cnt0, cnt1, total;
   logic [WIDTH-1:0] low, rng;
   logic [PW-1:0]    div_num, quo;
   logic             div_go, div_vld;
   logic             clear, upd, sym;
   logic [LEN_W-1:0] len_in;
   logic [WIDTH-1:0] offset;

   assign len_in  = (frame_len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : frame_len;
   assign clear   = (state_q == ST_IDLE) && start;
   assign div_go  = (state_q == ST_CHECK) && (idx_q != len_q);
   assign upd     = (state_q == ST_WAIT) && div_vld;
   assign div_num = PW'(rng) * PW'(cnt0);
   assign offset  = tag_q - low;
   assign sym     = (PW'(offset) >= quo);

   adec_model #(.CNT_W(CNT_W)) u_model (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .upd   (upd),
      .sym   (sym),
      .cnt0  (cnt0),
      .cnt1  (cnt1),
      .total (total)
   );

   adec_divider #(.NUM_W(PW), .DEN_W(CNT_W), .STEPS(STEPS_PER_CYCLE)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   (div_num),
      .den   (total),
      .quo   (quo),
      .vld   (div_vld)
   );

   adec_interval #(.WIDTH(WIDTH)) u_ivl (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .upd   (upd),
      .sym   (sym),
      .split (quo[WIDTH-1:0]),
      .low   (low),
      .rng   (rng)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tag_q   <= '0;
         len_q   <= '0;
         idx_q   <= '0;
         bit_q   <= 1'b0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  tag_q   <= tag_in;
                  len_q   <= len_in;
                  idx_q   <= '0;
                  done_q  <= 1'b0;
                  state_q <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (idx_q == len_q) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (div_vld) begin
                  bit_q   <= sym;
                  valid_q <= 1'b1;
                  idx_q   <= idx_q + LEN_W'(1);
                  state_q <= ST_CHECK;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bit_out   = bit_q;
   assign bit_valid = valid_q;
   assign done      = done_q;

endmodule

// File: rtl/adec_chk.sv
// Property checker for adec_top.
module adec_chk #(
   parameter int WIDTH = 64,
   parameter int CNT_W = 5,
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             bit_valid,
   input logic             done,
   input logic [CNT_W-1:0] c0,
   input logic [CNT_W-1:0] c1,
   input logic [LEN_W-1:0] idx,
   input logic [WIDTH-1:0] rng
);

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> !bit_valid);

   assert_no_valid_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> !done);

   assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(start));

   assert_count_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (8'(c0) + 8'(c1)) == (8'(idx) + 8'd2));

   assert_range_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rng != '0);

   assert_counts_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (c0 != '0) && (c1 != '0));

endmodule

bind adec_top adec_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .bit_valid (bit_valid),
   .done      (done),
   .c0        (cnt0),
   .c1        (cnt1),
   .idx       (idx_q),
   .rng       (rng)
);

// File: tb/adec_top_tb.sv
module adec_top_tb;

   localparam int WIDTH    = 64;
   localparam int MAX_BITS = 16;
   localparam int SPC      = 1;
   localparam int LEN_W    = $clog2(MAX_BITS + 1);
   localparam int CW       = $clog2(MAX_BITS + 3);
   localparam int P        = (WIDTH + CW + SPC - 1) / SPC + 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [WIDTH-1:0] tag_in = '0;
   logic [LEN_W-1:0] frame_len = '0;
   logic             bit_out, bit_valid, done;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   adec_top #(.WIDTH(WIDTH), .MAX_BITS(MAX_BITS), .STEPS_PER_CYCLE(SPC)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tag_in    (tag_in),
      .frame_len (frame_len),
      .bit_out   (bit_out),
      .bit_valid (bit_valid),
      .done      (done)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural encoder: final interval of an adaptive binary coder
   task automatic encode(input logic [MAX_BITS-1:0] fr, input int n,
                         output longint unsigned lo, output longint unsigned rg);
      longint unsigned l = 0;
      longint unsigned r = 64'hFFFF_FFFF_FFFF_FFFF;
      int z = 1;
      int o = 1;
      logic [WIDTH+CW-1:0] prod;
      longint unsigned sp;
      for (int i = 0; i < n; i++) begin
         prod = (WIDTH+CW)'(r) * (WIDTH+CW)'(z);
         sp   = 64'(prod / (WIDTH+CW)'(z + o));
         if (fr[i]) begin
            l = l + sp;
            r = r - sp;
            o++;
         end else begin
            r = sp;
            z++;
         end
      end
      lo = l;
      rg = r;
   endtask

   // one frame, compared against the timing model on every clock
   task automatic run_frame(input logic [MAX_BITS-1:0] fr, input int len_drv,
                            input int tsel, input bit inject);
      longint unsigned lo, rg, tg, off;
      int L;
      bit exp_v;
      L = (len_drv > MAX_BITS) ? MAX_BITS : len_drv;
      encode(fr, L, lo, rg);
      case (tsel)
         0: tg = lo;
         1: tg = lo + rg - 1;
         2: tg = lo + (rg >> 1);
         default: begin
            off = {$urandom, $urandom};
            tg  = lo + (off % rg);
         end
      endcase
      @(negedge clk);
      start     = 1'b1;
      tag_in    = tg;
      frame_len = LEN_W'(len_drv);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k <= L * P + 3; k++) begin
         exp_v = (k > 0) && (k % P == 0) && (k / P <= L);
         if (exp_v) begin
            check(bit_valid == 1'b1, "R7 strobe", longint'(bit_valid), 1);
            check(bit_out == fr[k/P-1], "R3 R4 R5 R6 bit", longint'(bit_out),
                  longint'(fr[k/P-1]));
         end else if (bit_valid) begin
            check(1'b0, "R7 spurious strobe", 1, 0);
         end
         if (k == L * P || k == L * P + 1) begin
            check(done == (k == L * P + 1), "R8 done edge", longint'(done),
                  longint'(k == L * P + 1));
         end else if (done != (k > L * P + 1)) begin
            check(1'b0, "R8 done level", longint'(done), longint'(k > L * P + 1));
         end
         if (inject && k == P + 3) begin
            start     = 1'b1;
            tag_in    = ~tg;
            frame_len = LEN_W'(3);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   initial begin
      logic [MAX_BITS-1:0] fr;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check(bit_valid == 1'b0, "R1 valid after reset", longint'(bit_valid), 0);
      check(done == 1'b0, "R1 done after reset", longint'(done), 0);

      run_frame('0, 16, 0, 1'b0);                 // all zeros, lowest tag
      run_frame('1, 16, 1, 1'b0);                 // all ones, highest tag
      run_frame(16'hA5C3, 16, 1, 1'b0);           // R6 upper edge
      run_frame(16'h3C96, 16, 0, 1'b0);           // R6 lower edge
      run_frame(16'h0001, 1, 2, 1'b0);            // single bit
      run_frame('0, 0, 0, 1'b0);                  // R8 empty frame
      run_frame(16'h9E37, 20, 2, 1'b0);           // R9 clamp to 16
      run_frame(16'h5A0F, 12, 3, 1'b1);           // R2 start ignored mid-frame
      repeat (5) @(negedge clk);
      check(done == 1'b1, "R8 done held", longint'(done), 1);
      for (int f = 0; f < 60; f++) begin
         fr = MAX_BITS'($urandom);
         run_frame(fr, 1 + ($urandom % MAX_BITS), f % 4, (f % 7) == 3);
      end
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule